// File: doc/BRIEF.md
# Cycle-Gated Memory Address Register

This block holds the address that a CPU presents to a core memory whose readout is destructive. The address is two bytes wide, and each byte has its own odd-parity bit, so the register is 18 bits. A selector places one of seven address sources on an internal assembly bus. The register takes that bus in at only one point: the first timing pulse of the read half of a storage cycle. From that point until the restore half of the same cycle ends, the address is locked, so the word that was read out and cleared is written back to the same location. The register output drives the memory address lines directly and passes through no gate.

A small sequencer has three states. `ST_OPEN` means a load may happen at the next read-half T1. `ST_HELD` means the cycle's address is committed and locked. `ST_STOPPED` means the CPU clock is stopped and the manual path is active. The transitions are: OPEN→HELD on a read-half T1, HELD→OPEN on a write-half T4, OPEN or HELD→STOPPED whenever `clk_run` is low, and STOPPED→OPEN when `clk_run` returns. While stopped, a manual set pulse loads the console-switch source. Two sticky flags report problems: a per-byte parity flag and a select-error flag.

Source index mapping on `src_sel`/`src_data`: indices 0–3 are the paired working registers, 4 is the fifth paired register, 5 is the console switches, and 6 is the control-store next-address field.

Top module: `mar_cycle_gate`

## Requirements
- R1: After reset, `addr_out` is 18'h20100, which is address zero with both parity bits set. `perr` is 00, `sel_err` is 0, and the sequencer is in `ST_OPEN`.
- R2: Byte k of the register occupies bits 9k+8:9k. Bits 9k+7:9k are address bits and bit 9k+8 is the parity bit. `addr_out` always equals the held register value, with no enable or gating.
- R3: The running load has five conditions: `clk_run`=1, `rd_half`=1, `tpulse[0]` (T1) is set, the sequencer is in `ST_OPEN`, and exactly one `src_sel` bit i is set. When all five hold, the register captures `src_data[i]` on that clock edge. `tpulse` is one-hot, with bits 0..3 standing for T1..T4. In any other running cycle the register does not change.
- R4: While `clk_run`=1 and `rd_half`=0 (the write/store half), `addr_out` does not change at any timing pulse.
- R5: A read-half T1 moves the sequencer to `ST_HELD`. Further T1 pulses are then ignored until a write-half T4 returns it to `ST_OPEN`.
- R6: `clk_run`=0 moves the sequencer to `ST_STOPPED`. In that state, `man_set`=1 loads `src_data[5]` regardless of `src_sel` and phase. When `clk_run` returns, the first cycle only re-arms the sequencer (to `ST_OPEN`) and does not load. `man_set` is ignored while `clk_run`=1.
- R7: If, at a read-half T1 in `ST_OPEN`, zero or more than one `src_sel` bit is set, no load happens and `sel_err` is set. The sequencer still goes to `ST_HELD`. `sel_err` stays set until `err_clr`. A new error in the same cycle as `err_clr` wins, leaving the flag set.
- R8: Each byte uses odd parity: its 9 bits must contain an odd number of ones. A load of a byte that fails this check sets `perr[k]`. The flag is sticky until `err_clr`, with the same priority as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_run | input | 1 | 1 when the CPU clock is running |
| rd_half | input | 1 | 1 during the read half, 0 during the write/store half |
| tpulse | input | 4 | One-hot timing pulse, bit 0 = T1 to bit 3 = T4 |
| src_sel | input | 7 | One-hot source select |
| src_data | input | 7×18 | Address value of each source |
| man_set | input | 1 | Manual set pulse, active while stopped |
| err_clr | input | 1 | Clears the sticky error flags |
| addr_out | output | 18 | Address with parity, to memory addressing |
| perr | output | 2 | Sticky parity error, one per byte |
| sel_err | output | 1 | Sticky select error |

## Verification
The bench builds the block with its default parameters: two 8-bit bytes and seven sources, with the console at index 5. This makes every source, both parity bytes and all four timing pulses reachable. One source is given a deliberately bad high-byte parity, so the sticky flag can be shown setting, holding across a later clean load, and clearing. The stimulus walks complete read-then-restore cycles, including a repeated T1 with no restore in between, a write-half T1, stop and restart of the clock, and a manual load.

// File: rtl/mar_pkg.sv
package mar_pkg;

    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_HELD    = 2'd1,
        ST_STOPPED = 2'd2
    } cyc_state_e;

    localparam int unsigned TP_FIRST = 0;
    localparam int unsigned TP_LAST  = 3;
    localparam int unsigned TP_COUNT = 4;

endpackage

// File: rtl/mar_src_mux.sv
module mar_src_mux #(
    parameter int unsigned NSRC = 7,
    parameter int unsigned W    = 18,
    parameter int unsigned CON  = 5
) (
    input  logic [NSRC-1:0]        sel,
    input  logic [NSRC-1:0][W-1:0] data,
    input  logic                   force_con,
    output logic [W-1:0]           bus,
    output logic                   sel_ok
);

    logic [NSRC-1:0][W-1:0] gated;
    logic [W-1:0]           merged;

    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign gated[i] = data[i] & {W{sel[i]}};
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < NSRC; i++) begin
            merged = merged | gated[i];
        end
    end

    assign sel_ok = $onehot(sel);
    assign bus    = force_con ? data[CON] : merged;

endmodule

// File: rtl/mar_cycle_fsm.sv
module mar_cycle_fsm
    import mar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_run,
    input  logic       rd_half,
    input  logic       t1,
    input  logic       t4,
    input  logic       sel_ok,
    input  logic       man_set,
    input  logic       err_clr,
    output logic       ld_run,
    output logic       ld_man,
    output logic       sel_err,
    output cyc_state_e state
);

    cyc_state_e state_nxt;
    logic       sel_fault;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN: begin
                if (!clk_run)              state_nxt = ST_STOPPED;
                else if (rd_half && t1)    state_nxt = ST_HELD;
            end
            ST_HELD: begin
                if (!clk_run)              state_nxt = ST_STOPPED;
                else if (!rd_half && t4)   state_nxt = ST_OPEN;
            end
            ST_STOPPED: begin
                if (clk_run)               state_nxt = ST_OPEN;
            end
            default:                       state_nxt = ST_OPEN;
        endcase
    end

    always_comb begin
        ld_run    = 1'b0;
        ld_man    = 1'b0;
        sel_fault = 1'b0;
        unique case (state)
            ST_OPEN: begin
                ld_run    = clk_run && rd_half && t1 && sel_ok;
                sel_fault = clk_run && rd_half && t1 && !sel_ok;
            end
            ST_HELD: begin
            end
            ST_STOPPED: begin
                ld_man    = !clk_run && man_set;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_err <= 1'b0;
        else        sel_err <= (sel_err && !err_clr) || sel_fault;
    end

endmodule

// File: rtl/mar_byte_slice.sv
module mar_byte_slice #(
    parameter int unsigned BW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          clr,
    input  logic [BW-1:0] din,
    output logic [BW-1:0] q,
    output logic          perr
);

    localparam logic [BW-1:0] Q_RST = {1'b1, {(BW-1){1'b0}}};

    logic bad;
    assign bad = ~(^din);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= Q_RST;
            perr <= 1'b0;
        end else begin
            if (ld) q <= din;
            perr <= (perr && !clr) || (ld && bad);
        end
    end

endmodule

// File: rtl/mar_cycle_gate.sv
module mar_cycle_gate
    import mar_pkg::*;
#(
    parameter int unsigned NBYTES = 2,
    parameter int unsigned DBITS  = 8,
    parameter int unsigned NSRC   = 7,
    parameter int unsigned CON    = 5
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    clk_run,
    input  logic                                    rd_half,
    input  logic [TP_COUNT-1:0]                     tpulse,
    input  logic [NSRC-1:0]                         src_sel,
    input  logic [NSRC-1:0][NBYTES*(DBITS+1)-1:0]   src_data,
    input  logic                                    man_set,
    input  logic                                    err_clr,
    output logic [NBYTES*(DBITS+1)-1:0]             addr_out,
    output logic [NBYTES-1:0]                       perr,
    output logic                                    sel_err
);

    localparam int unsigned BW = DBITS + 1;
    localparam int unsigned W  = NBYTES * BW;

    cyc_state_e   cyc_state;
    logic         ld_run;
    logic         ld_man;
    logic         sel_ok;
    logic         ld_any;
    logic [W-1:0] asm_bus;

    mar_src_mux #(.NSRC(NSRC), .W(W), .CON(CON)) u_mux (
        .sel       (src_sel),
        .data      (src_data),
        .force_con (ld_man),
        .bus       (asm_bus),
        .sel_ok    (sel_ok)
    );

    mar_cycle_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_run (clk_run),
        .rd_half (rd_half),
        .t1      (tpulse[TP_FIRST]),
        .t4      (tpulse[TP_LAST]),
        .sel_ok  (sel_ok),
        .man_set (man_set),
        .err_clr (err_clr),
        .ld_run  (ld_run),
        .ld_man  (ld_man),
        .sel_err (sel_err),
        .state   (cyc_state)
    );

    assign ld_any = ld_run || ld_man;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        mar_byte_slice #(.BW(BW)) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (ld_any),
            .clr   (err_clr),
            .din   (asm_bus[k*BW +: BW]),
            .q     (addr_out[k*BW +: BW]),
            .perr  (perr[k])
        );
    end

endmodule

// File: rtl/mar_cycle_gate_chk.sv
module mar_cycle_gate_chk
    import mar_pkg::*;
#(
    parameter int unsigned NBYTES = 2,
    parameter int unsigned DBITS  = 8,
    parameter int unsigned NSRC   = 7,
    parameter int unsigned CON    = 5
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  clk_run,
    input logic                                  rd_half,
    input logic [TP_COUNT-1:0]                   tpulse,
    input logic [NSRC-1:0]                       src_sel,
    input logic [NSRC-1:0][NBYTES*(DBITS+1)-1:0] src_data,
    input logic                                  man_set,
    input logic                                  err_clr,
    input logic [NBYTES*(DBITS+1)-1:0]           addr_out,
    input logic [NBYTES-1:0]                     perr,
    input logic                                  sel_err,
    input cyc_state_e                            cyc_state
);

    p_not_t1_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && !tpulse[TP_FIRST]) |=> $stable(addr_out));

    p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && !rd_half) |=> $stable(addr_out));

    p_held_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && cyc_state == ST_HELD) |=> $stable(addr_out));

    p_manual_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_run && man_set && cyc_state == ST_STOPPED)
        |=> (addr_out == $past(src_data[CON])));

    p_sel_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && rd_half && tpulse[TP_FIRST] && cyc_state == ST_OPEN
         && $countones(src_sel) != 1) |=> (sel_err && $stable(addr_out)));

    p_sel_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_err && !err_clr) |=> sel_err);

    p_perr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (perr != '0 && !err_clr) |=> ((perr & $past(perr)) == $past(perr)));

endmodule

bind mar_cycle_gate mar_cycle_gate_chk #(
    .NBYTES (NBYTES),
    .DBITS  (DBITS),
    .NSRC   (NSRC),
    .CON    (CON)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_run   (clk_run),
    .rd_half   (rd_half),
    .tpulse    (tpulse),
    .src_sel   (src_sel),
    .src_data  (src_data),
    .man_set   (man_set),
    .err_clr   (err_clr),
    .addr_out  (addr_out),
    .perr      (perr),
    .sel_err   (sel_err),
    .cyc_state (cyc_state)
);

// File: tb/mar_cycle_gate_tb.sv
module mar_cycle_gate_tb;

    function automatic logic [17:0] enc(input logic [7:0] hi, input logic [7:0] lo);
        return {~^hi, hi, ~^lo, lo};
    endfunction

    localparam logic [17:0] RSTV = 18'h20100;
    localparam logic [17:0] SV0  = enc(8'h12, 8'h34);
    localparam logic [17:0] SV1  = enc(8'hA5, 8'h0F);
    localparam logic [17:0] SV2  = enc(8'h00, 8'hFF);
    localparam logic [17:0] SV3  = enc(8'h3C, 8'h81) ^ 18'h20000;
    localparam logic [17:0] SV4  = enc(8'h7E, 8'h01);
    localparam logic [17:0] SV5  = enc(8'hC3, 8'h55);
    localparam logic [17:0] SV6  = enc(8'hFE, 8'hDC);

    typedef struct packed {
        logic [3:0]  rq;
        logic        run;
        logic        rd;
        logic [3:0]  tp;
        logic [6:0]  sel;
        logic        man;
        logic        clr;
        logic [17:0] ea;
        logic [1:0]  ep;
        logic        es;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{4'd3, 1'b1, 1'b1, 4'b0010, 7'b0000001, 1'b0, 1'b0, RSTV, 2'b00, 1'b0}, // R3 read T2 no load
        '{4'd3, 1'b1, 1'b1, 4'b0001, 7'b0000001, 1'b0, 1'b0, SV0,  2'b00, 1'b0}, // R3 load src0
        '{4'd5, 1'b1, 1'b1, 4'b0010, 7'b0000010, 1'b0, 1'b0, SV0,  2'b00, 1'b0}, // R5
        '{4'd4, 1'b1, 1'b0, 4'b0100, 7'b0000010, 1'b0, 1'b0, SV0,  2'b00, 1'b0}, // R4
        '{4'd4, 1'b1, 1'b0, 4'b1000, 7'b0000010, 1'b0, 1'b0, SV0,  2'b00, 1'b0}, // R4 restore end
        '{4'd3, 1'b1, 1'b1, 4'b0001, 7'b0000010, 1'b0, 1'b0, SV1,  2'b00, 1'b0}, // R3 load src1
        '{4'd5, 1'b1, 1'b1, 4'b0001, 7'b0000100, 1'b0, 1'b0, SV1,  2'b00, 1'b0}, // R5 second T1
        '{4'd4, 1'b1, 1'b0, 4'b0001, 7'b0000100, 1'b0, 1'b0, SV1,  2'b00, 1'b0}, // R4 write T1
        '{4'd5, 1'b1, 1'b0, 4'b1000, 7'b0000100, 1'b0, 1'b0, SV1,  2'b00, 1'b0}, // R5 reopen
        '{4'd4, 1'b1, 1'b0, 4'b0001, 7'b0000100, 1'b0, 1'b0, SV1,  2'b00, 1'b0}, // R4 open write T1
        '{4'd7, 1'b1, 1'b1, 4'b0001, 7'b1010000, 1'b0, 1'b0, SV1,  2'b00, 1'b1}, // R7 two selects
        '{4'd7, 1'b1, 1'b0, 4'b1000, 7'b0000000, 1'b0, 1'b0, SV1,  2'b00, 1'b1}, // R7 sticky
        '{4'd7, 1'b1, 1'b1, 4'b0001, 7'b0000000, 1'b0, 1'b1, SV1,  2'b00, 1'b1}, // R7 none, set wins
        '{4'd7, 1'b1, 1'b0, 4'b1000, 7'b0000000, 1'b0, 1'b1, SV1,  2'b00, 1'b0}, // R7 clear
        '{4'd8, 1'b1, 1'b1, 4'b0001, 7'b0001000, 1'b0, 1'b0, SV3,  2'b10, 1'b0}, // R8 bad high byte
        '{4'd8, 1'b1, 1'b0, 4'b1000, 7'b0000000, 1'b0, 1'b0, SV3,  2'b10, 1'b0}, // R8 sticky
        '{4'd8, 1'b1, 1'b1, 4'b0001, 7'b1000000, 1'b0, 1'b0, SV6,  2'b10, 1'b0}, // R8 clean load keeps
        '{4'd8, 1'b1, 1'b0, 4'b1000, 7'b0000000, 1'b0, 1'b1, SV6,  2'b00, 1'b0}, // R8 clear
        '{4'd6, 1'b0, 1'b1, 4'b0001, 7'b0000001, 1'b0, 1'b0, SV6,  2'b00, 1'b0}, // R6 stop, no load
        '{4'd6, 1'b0, 1'b0, 4'b0100, 7'b0000001, 1'b1, 1'b0, SV5,  2'b00, 1'b0}, // R6 manual console
        '{4'd6, 1'b0, 1'b1, 4'b0001, 7'b0000001, 1'b0, 1'b0, SV5,  2'b00, 1'b0}, // R6 stopped hold
        '{4'd6, 1'b1, 1'b1, 4'b0001, 7'b0000001, 1'b0, 1'b0, SV5,  2'b00, 1'b0}, // R6 rearm only
        '{4'd3, 1'b1, 1'b1, 4'b0001, 7'b0000001, 1'b0, 1'b0, SV0,  2'b00, 1'b0}, // R3 load after rearm
        '{4'd6, 1'b1, 1'b0, 4'b1000, 7'b0000000, 1'b1, 1'b0, SV0,  2'b00, 1'b0}, // R6 man ignored running
        '{4'd2, 1'b1, 1'b1, 4'b0001, 7'b0010000, 1'b0, 1'b0, SV4,  2'b00, 1'b0}  // R2 R3 src4 direct
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clk_run;
    logic             rd_half;
    logic [3:0]       tpulse;
    logic [6:0]       src_sel;
    logic [6:0][17:0] src_data;
    logic             man_set;
    logic             err_clr;
    logic [17:0]      addr_out;
    logic [1:0]       perr;
    logic             sel_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mar_cycle_gate u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_run  (clk_run),
        .rd_half  (rd_half),
        .tpulse   (tpulse),
        .src_sel  (src_sel),
        .src_data (src_data),
        .man_set  (man_set),
        .err_clr  (err_clr),
        .addr_out (addr_out),
        .perr     (perr),
        .sel_err  (sel_err)
    );

    task automatic chk(input int rq, input logic [17:0] ea, input logic [1:0] ep, input logic es);
        n_chk++;
        if (addr_out !== ea || perr !== ep || sel_err !== es) begin
            n_err++;
            $display("FAIL R%0d: addr=%h perr=%b sel_err=%b expected addr=%h perr=%b sel_err=%b",
                     rq, addr_out, perr, sel_err, ea, ep, es);
        end
    endtask

    task automatic drive(input logic run, input logic rd, input logic [3:0] tp,
                         input logic [6:0] sel, input logic man, input logic clr);
        clk_run = run;
        rd_half = rd;
        tpulse  = tp;
        src_sel = sel;
        man_set = man;
        err_clr = clr;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        src_data = {SV6, SV5, SV4, SV3, SV2, SV1, SV0};
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 4'b0000, 7'b0000000, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(1, RSTV, 2'b00, 1'b0); // R1 reset state

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].run, VEC[i].rd, VEC[i].tp, VEC[i].sel, VEC[i].man, VEC[i].clr);
            @(negedge clk);
            chk(int'(VEC[i].rq), VEC[i].ea, VEC[i].ep, VEC[i].es);
        end

        // R7 create an error, then reset clears it (R1)
        drive(1'b1, 1'b0, 4'b1000, 7'b0000000, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b1, 1'b1, 4'b0001, 7'b0000000, 1'b0, 1'b0);
        @(negedge clk);
        chk(7, SV4, 2'b00, 1'b1); // R7 no select at T1
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 4'b0000, 7'b0000000, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        chk(1, RSTV, 2'b00, 1'b0); // R1 mid-run reset

        // R1 sequencer open after reset: a read T1 loads at once
        drive(1'b1, 1'b1, 4'b0001, 7'b0000100, 1'b0, 1'b0);
        @(negedge clk);
        chk(1, SV2, 2'b00, 1'b0);

        // R2 output equals held value through a full restore half
        drive(1'b1, 1'b0, 4'b0010, 7'b0000001, 1'b0, 1'b0);
        @(negedge clk);
        chk(2, SV2, 2'b00, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule